// File: doc/BRIEF.md
# Emergency Output Shutdown Controller

This block protects a power stage. It watches a small set of active-low shutdown request pins. Once a request qualifies, it pulls every output-enable line of a six-pin three-phase PWM group low, which places those pins in high impedance. Each request pin is configured on its own. It can react to a single falling edge, or it can wait for a run of consecutive low samples taken at one of three divided rates of the block clock. The level modes filter out short glitches on a noisy fault line.

Every qualified request sets a sticky status flag. Each flag can drive a shared interrupt line through its own enable bit. The output group stays in high impedance while any flag is set. Software releases it with a read-then-clear handshake, and only once the request pin has gone inactive. A standby indication or an oscillator-halt indication from elsewhere in the chip also forces the group to high impedance while either one is asserted. A two-entry register port gives access to the configuration and the flags.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset the configuration register reads 0 (edge mode, input disabled, interrupt disabled for every input), the status register reads 0, every `out_en` bit is 1 and `irq` is 0.
- R2: In edge mode (mode code 0) on an enabled input, a falling edge on its pin sets that input's flag on the third rising clock edge after the pin changes. This allows two synchronizer stages plus the flag register.
- R3: In a level mode, the synchronized pin is sampled once per tick of the clock divided by 8 (mode code 1), 16 (code 2) or 128 (code 3). The flag sets when 16 consecutive samples are low. Any high sample restarts the count from zero.
- R4: An input whose enable bit is 0 never sets its flag, whatever its pin does.
- R5: While any flag is set, all six `out_en` bits are 0. A qualification on any single input is enough.
- R6: While `standby` or `osc_halt` is 1, all `out_en` bits are 0, with no clock delay. `out_en` returns to all ones only when every flag is clear and both of these inputs are 0.
- R7: `irq` is 1 exactly when some input has both its flag and its interrupt enable bit set.
- R8: Writing 0 to a flag bit clears it only if that flag was read as 1 since it was last set, and only if the input is not enabled with its synchronized pin low. Writing 1 has no effect.
- R9: The register map is as follows.
  - Address 0 is configuration. Input i has its mode in bits [2i+1:2i], its enable in bit 8+i and its interrupt enable in bit 12+i. All other bits read 0.
  - Address 1 is status. The flag of input i is in bit i, and the upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register address: 0 configuration, 1 status |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; marks flags read as 1 for clearing |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| sd_n | input | 3 | Active-low shutdown request pins |
| standby | input | 1 | Standby indication, forces high impedance |
| osc_halt | input | 1 | Oscillator-halt indication, forces high impedance |
| out_en | output | 6 | Output enables of the PWM pin group; 0 means high impedance |
| irq | output | 1 | Interrupt request |

## Verification
A wrong sample counter or divider selection in a level mode shows up as a flag that sets outside its window. That window opens 15 divider periods after the pin falls and closes one period later, so an error becomes visible within about 16 ticks of the selected rate. A flag register that sets spuriously, fails to set, or clears when it should not shows up at once on `out_en`, on `irq` and on the status read. A clear that slips past the read handshake leaves the power stage released one write early, and the next status read exposes it. The forcing path from standby and oscillator-halt is combinational, so any fault in it is visible on `out_en` in the same cycle.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
   localparam int REG_W  = 16;
   localparam int EN_LSB = 8;
   localparam int IE_LSB = 12;
   localparam int MAX_IN = 4;

   localparam logic ADDR_CTRL = 1'b0;
   localparam logic ADDR_STAT = 1'b1;

   typedef enum logic [1:0] {
      QM_EDGE  = 2'd0,
      QM_DIV_A = 2'd1,
      QM_DIV_B = 2'd2,
      QM_DIV_C = 2'd3
   } qual_mode_e;

   function automatic logic [REG_W-1:0] ctrl_mask(input int n);
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < n; i++) begin
         m[2*i +: 2]    = 2'b11;
         m[EN_LSB + i]  = 1'b1;
         m[IE_LSB + i]  = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/pfg_prescaler.sv
module pfg_prescaler #(
   parameter int DIV_A = 8,
   parameter int DIV_B = 16,
   parameter int DIV_C = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic [2:0] tick
);
   localparam int CW = $clog2(DIV_C);
   localparam int DIVS [3] = '{DIV_A, DIV_B, DIV_C};

   if (DIV_A < 2 || (DIV_A & (DIV_A - 1)) != 0) begin : g_bad_a
      $error("pfg_prescaler: DIV_A must be a power of two of at least 2");
   end
   if (DIV_B < 2 || (DIV_B & (DIV_B - 1)) != 0) begin : g_bad_b
      $error("pfg_prescaler: DIV_B must be a power of two of at least 2");
   end
   if (DIV_C < 2 || (DIV_C & (DIV_C - 1)) != 0) begin : g_bad_c
      $error("pfg_prescaler: DIV_C must be a power of two of at least 2");
   end
   if (DIV_A > DIV_C || DIV_B > DIV_C) begin : g_bad_order
      $error("pfg_prescaler: DIV_C must be the largest divider");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   for (genvar k = 0; k < 3; k++) begin : g_tick
      localparam logic [CW-1:0] MSK = CW'(DIVS[k] - 1);
      assign tick[k] = ((cnt & MSK) == MSK);
   end
endmodule

// File: rtl/pfg_input_qual.sv
module pfg_input_qual
   import pfg_pkg::*;
#(
   parameter int SAMPLES = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_n,
   input  logic       enable,
   input  logic [1:0] mode,
   input  logic [2:0] tick,
   output logic       qual,
   output logic       pin_low
);
   localparam int CNW = $clog2(SAMPLES + 1);

   if (SAMPLES < 2) begin : g_bad_samples
      $error("pfg_input_qual: SAMPLES must be at least 2");
   end

   qual_mode_e m;
   logic       s1, s2, prev;
   logic       fall, sel_tick, level_hit;
   logic [CNW-1:0] run_cnt;

   assign m = qual_mode_e'(mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1   <= 1'b1;
         s2   <= 1'b1;
         prev <= 1'b1;
      end else begin
         s1   <= pin_n;
         s2   <= s1;
         prev <= s2;
      end
   end

   assign fall    = prev & ~s2;
   assign pin_low = ~s2;

   always_comb begin
      case (m)
         QM_DIV_A: sel_tick = tick[0];
         QM_DIV_B: sel_tick = tick[1];
         QM_DIV_C: sel_tick = tick[2];
         default:  sel_tick = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (!enable || m == QM_EDGE) begin
         run_cnt <= '0;
      end else if (sel_tick) begin
         if (s2)                              run_cnt <= '0;
         else if (run_cnt != CNW'(SAMPLES))   run_cnt <= run_cnt + 1'b1;
      end
   end

   assign level_hit = sel_tick && !s2 && (run_cnt == CNW'(SAMPLES - 1));
   assign qual      = enable && ((m == QM_EDGE) ? fall : level_hit);
endmodule

// File: rtl/pfg_regs.sv
module pfg_regs
   import pfg_pkg::*;
#(
   parameter int N_IN = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_sel,
   input  logic                  reg_wr,
   input  logic                  reg_rd,
   input  logic [REG_W-1:0]      reg_wdata,
   output logic [REG_W-1:0]      reg_rdata,
   input  logic [N_IN-1:0]       qual,
   input  logic [N_IN-1:0]       pin_low,
   output logic [N_IN-1:0][1:0]  mode,
   output logic [N_IN-1:0]       en,
   output logic [N_IN-1:0]       ie,
   output logic [N_IN-1:0]       flags
);
   localparam logic [REG_W-1:0] CTRL_MASK = ctrl_mask(N_IN);

   if (N_IN < 1 || N_IN > MAX_IN) begin : g_bad_nin
      $error("pfg_regs: N_IN must be between 1 and 4");
   end

   logic [REG_W-1:0] ctrl_q;
   logic             wr_ctrl, wr_stat, rd_stat;

   assign wr_ctrl = reg_wr && (reg_sel == ADDR_CTRL);
   assign wr_stat = reg_wr && (reg_sel == ADDR_STAT);
   assign rd_stat = reg_rd && (reg_sel == ADDR_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_MASK;
   end

   for (genvar i = 0; i < N_IN; i++) begin : g_in
      logic armed, clr_ok, flag_d;

      assign mode[i] = ctrl_q[2*i +: 2];
      assign en[i]   = ctrl_q[EN_LSB + i];
      assign ie[i]   = ctrl_q[IE_LSB + i];

      assign clr_ok = wr_stat && !reg_wdata[i] && armed && !(en[i] && pin_low[i]);
      assign flag_d = qual[i] ? 1'b1 : (clr_ok ? 1'b0 : flags[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags[i] <= 1'b0;
            armed    <= 1'b0;
         end else begin
            flags[i] <= flag_d;
            if (!flag_d)                   armed <= 1'b0;
            else if (rd_stat && flags[i])  armed <= 1'b1;
         end
      end
   end

   assign reg_rdata = (reg_sel == ADDR_STAT) ? REG_W'(flags) : ctrl_q;
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
   import pfg_pkg::*;
#(
   parameter int N_IN    = 3,
   parameter int N_OUT   = 6,
   parameter int SAMPLES = 16,
   parameter int DIV_A   = 8,
   parameter int DIV_B   = 16,
   parameter int DIV_C   = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   input  logic [N_IN-1:0]   sd_n,
   input  logic              standby,
   input  logic              osc_halt,
   output logic [N_OUT-1:0]  out_en,
   output logic              irq
);
   if (REG_W != 16) begin : g_bad_regw
      $error("pwm_fault_guard: register width must be 16");
   end
   if (N_OUT < 1) begin : g_bad_nout
      $error("pwm_fault_guard: N_OUT must be at least 1");
   end

   logic [2:0]            tick;
   logic [N_IN-1:0][1:0]  in_mode;
   logic [N_IN-1:0]       in_en, in_ie, flags, qual_pulse, pin_low;
   logic                  force_hiz;

   pfg_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   for (genvar i = 0; i < N_IN; i++) begin : g_qual
      pfg_input_qual #(.SAMPLES(SAMPLES)) u_q (
         .clk(clk), .rst_n(rst_n), .pin_n(sd_n[i]), .enable(in_en[i]),
         .mode(in_mode[i]), .tick(tick), .qual(qual_pulse[i]), .pin_low(pin_low[i])
      );
   end

   pfg_regs #(.N_IN(N_IN)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .qual(qual_pulse), .pin_low(pin_low),
      .mode(in_mode), .en(in_en), .ie(in_ie), .flags(flags)
   );

   assign force_hiz = (|flags) | standby | osc_halt;
   assign out_en    = {N_OUT{~force_hiz}};
   assign irq       = |(flags & in_ie);
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
   parameter int N_IN  = 3,
   parameter int N_OUT = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_sel,
   input logic             reg_wr,
   input logic [N_IN-1:0]  flags,
   input logic [N_IN-1:0]  en,
   input logic [N_IN-1:0]  qual,
   input logic             standby,
   input logic             osc_halt,
   input logic [N_OUT-1:0] out_en,
   input logic             irq
);
   for (genvar i = 0; i < N_IN; i++) begin : g_chk
      AST_QUAL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         qual[i] |=> flags[i]); // R2
      AST_SET_ONLY_BY_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flags[i]) |-> $past(qual[i])); // R2
      AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !en[i] |-> !qual[i]); // R4
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && !(reg_wr && reg_sel)) |=> flags[i]); // R8
   end

   AST_HIZ_AFTER_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (|qual) |=> (out_en == '0)); // R5
   AST_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_en[0]) |-> (flags == '0 && !standby && !osc_halt)); // R6
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|flags)); // R7
endmodule

bind pwm_fault_guard pfg_checker #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .flags(flags),
   .en(in_en), .qual(qual_pulse), .standby(standby), .osc_halt(osc_halt),
   .out_en(out_en), .irq(irq)
);

// File: tb/sim_pwm_fault_guard.sv
`timescale 1ns/1ps
module sim_pwm_fault_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [2:0]  sd_n = 3'b111;
   logic        standby = 1'b0, osc_halt = 1'b0;
   logic [5:0]  out_en;
   logic        irq;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   pwm_fault_guard u0 (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sd_n(sd_n), .standby(standby),
      .osc_halt(osc_halt), .out_en(out_en), .irq(irq)
   );

   function automatic logic [5:0] exp_oe(input logic [2:0] fl, input logic sb, input logic oh);
      return (|fl || sb || oh) ? 6'h00 : 6'h3f;
   endfunction

   function automatic logic exp_irq(input logic [2:0] fl, input logic [2:0] ie);
      return |(fl & ie);
   endfunction

   function automatic logic [15:0] ctrl_word(input logic [2:0] en, input logic [2:0] ie,
                                             input logic [5:0] modes);
      return {1'b0, ie, 1'b0, en, 2'b00, modes};
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic a, input logic [15:0] d);
      reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
      step(1);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [15:0] d);
      reg_sel = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      step(1);
      reg_rd = 1'b0;
   endtask

   function automatic logic [15:0] peek_stat();
      return reg_rdata;
   endfunction

   task automatic peek(input logic a, output logic [15:0] d);
      reg_sel = a;
      #1 d = reg_rdata;
   endtask

   task automatic clear_flag(input int idx);
      logic [15:0] d;
      rd(1'b1, d);
      wr(1'b1, 16'h7 & ~(16'h1 << idx));
   endtask

   task automatic level_test(input int idx, input logic [1:0] mcode, input int div, input bit ie_on);
      logic [15:0] d;
      logic [2:0]  en_v, ie_v;
      logic [5:0]  md;
      en_v = 3'b000; en_v[idx] = 1'b1;
      ie_v = 3'b000; ie_v[idx] = ie_on;
      md = '0; md[2*idx +: 2] = mcode;
      wr(1'b0, ctrl_word(en_v, ie_v, md));
      // glitch: low for 10 periods, then high long enough to be sampled
      sd_n[idx] = 1'b0;
      step(10 * div);
      sd_n[idx] = 1'b1;
      step(div + 3);
      sd_n[idx] = 1'b0;
      step(15 * div + 1);
      peek(1'b1, d);
      check($sformatf("R3 no flag before 16 samples (in%0d div%0d)", idx, div), d, 16'h0);
      check("R5 outputs still driven before qualification", out_en, 6'h3f);
      step(div + 2);
      peek(1'b1, d);
      check($sformatf("R3 flag after 16 low samples (in%0d div%0d)", idx, div), d, 16'h1 << idx);
      check("R5 all six outputs released to high impedance", out_en, exp_oe(d[2:0], 1'b0, 1'b0));
      check("R7 irq follows per-input enable", irq, exp_irq(d[2:0], ie_v));
      sd_n[idx] = 1'b1;
      step(3);
      clear_flag(idx);
      peek(1'b1, d);
      check("R8 flag cleared after read then write 0", d, 16'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      void'($urandom(32'h5eed));
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      peek(1'b0, d); check("R1 config after reset", d, 16'h0);
      peek(1'b1, d); check("R1 status after reset", d, 16'h0);
      check("R1 out_en after reset", out_en, 6'h3f);
      check("R1 irq after reset", irq, 1'b0);

      // R9 register layout, unused bits read 0
      wr(1'b0, 16'hffff);
      peek(1'b0, d); check("R9 config writable bits", d, 16'h773f);
      wr(1'b0, ctrl_word(3'b001, 3'b001, 6'b0));
      peek(1'b0, d); check("R9 config readback", d, 16'h1100);

      // R2 edge latency
      sd_n[0] = 1'b0;
      step(2);
      check("R2 no flag two edges after fall", out_en, 6'h3f);
      step(1);
      peek(1'b1, d);
      check("R2 flag on third edge", d, 16'h1);
      check("R5 out_en low on flag", out_en, 6'h00);
      check("R7 irq with enabled flag", irq, 1'b1);

      // R8 clear blocked while pin still low
      rd(1'b1, d);
      check("R9 status read as 1", d, 16'h1);
      wr(1'b1, 16'h0);
      peek(1'b1, d); check("R8 clear ignored while pin low", d, 16'h1);
      sd_n[0] = 1'b1;
      step(3);
      wr(1'b1, 16'h7);
      peek(1'b1, d); check("R8 writing 1 has no effect", d, 16'h1);
      wr(1'b1, 16'h0);
      peek(1'b1, d); check("R8 clear after read", d, 16'h0);
      check("R6 out_en released once clear", out_en, 6'h3f);
      check("R7 irq drops with flag", irq, 1'b0);

      // R8 clear without prior read is ignored
      sd_n[0] = 1'b0; step(4); sd_n[0] = 1'b1; step(3);
      wr(1'b1, 16'h0);
      peek(1'b1, d); check("R8 clear without read ignored", d, 16'h1);
      clear_flag(0);
      peek(1'b1, d); check("R8 clear after read succeeds", d, 16'h0);

      // R4 disabled input
      sd_n[1] = 1'b0; step(12); sd_n[1] = 1'b1; step(4);
      peek(1'b1, d); check("R4 disabled input sets no flag", d, 16'h0);
      check("R4 disabled input leaves outputs driven", out_en, 6'h3f);

      // R3 level modes at each divider
      level_test(1, 2'd1, 8, 1'b0);
      level_test(0, 2'd2, 16, 1'b1);
      level_test(2, 2'd3, 128, 1'b1);

      // R6 random standby / oscillator-halt with no flags
      for (int k = 0; k < 30; k++) begin
         standby  = $urandom_range(0, 1);
         osc_halt = $urandom_range(0, 1);
         #1;
         check("R6 standby/osc_halt force", out_en, exp_oe(3'b0, standby, osc_halt));
         step(1);
      end
      standby = 1'b0; osc_halt = 1'b0;

      // R6 flag keeps outputs off after standby drops
      wr(1'b0, ctrl_word(3'b111, 3'b000, 6'b0));
      standby = 1'b1;
      sd_n = 3'b000; step(4); sd_n = 3'b111; step(3);
      standby = 1'b0; #1;
      check("R6 flags hold high impedance after standby", out_en, 6'h00);

      // R7 random interrupt masks with all three flags set
      for (int k = 0; k < 20; k++) begin
         logic [2:0] ie_r;
         ie_r = 3'($urandom_range(0, 7));
         wr(1'b0, ctrl_word(3'b111, ie_r, 6'b0));
         check("R7 irq under random mask", irq, exp_irq(3'b111, ie_r));
      end
      rd(1'b1, d);
      wr(1'b1, 16'h5);
      peek(1'b1, d); check("R8 selective clear of input 1", d, 16'h5);
      wr(1'b0, ctrl_word(3'b111, 3'b010, 6'b0));
      check("R7 irq off when enabled flag cleared", irq, 1'b0);
      wr(1'b1, 16'h0);
      peek(1'b1, d); check("R8 clear remaining flags", d, 16'h0);
      check("R6 release after all clear", out_en, 6'h3f);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule